// File: doc/BRIEF.md
# Vector Multiply, Dot Product and Scaled-Add Unit

This unit executes the multiply group of a vector instruction set against an external register file of 128 words of 32 bits. One instruction word describes a run of consecutive registers. The unit walks that run one element per clock. For each element it reads two source registers, multiplies them and writes the scaled product back. Three kinds of work are supported: element-wise products, a dot product that folds every product into one result, and a scaled add. The scaled add multiplies each A element by the value held in register 1 and then adds B.

The opcode selects the operand widths. A 16-bit operand is the low half of a register taken as signed. The opcode also selects an arithmetic right shift of 0, 8 or 16 bits, applied after the multiply. An optional rounding bit biases the value by half of one unit of the shifted result before the shift. The register file is outside the block. The unit drives two read indices and receives the data back in the same cycle. It also receives register 1 on a separate scale input. Results go out on a single write port.

Top module: `vms_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `wr_en` are all low.
- R2: Field layout of `instr`: mode in bits 31:28, element count in 27:24, round in 23, operation in 22:21, source A index in 20:14, destination index in 13:7, source B index in 6:0. A legal instruction processes count+1 elements. The A, B and D indices advance by one per element and wrap modulo 128.
- R3: Modes 0, 1 and 2 multiply the signed low 16 bits of A by the signed low 16 bits of B, then shift arithmetically right by 0, 8 and 16 bits. The low 32 bits are the result.
- R4: Modes 4, 5 and 6 multiply the full signed 32-bit A by the signed low 16 bits of B, with the same three shifts. The low 32 bits are the result.
- R5: When bit 23 is set and the shift is nonzero, 2^(shift-1) is added before the shift. With a shift of 0, the round bit has no effect.
- R6: Operation 0 writes each scaled product to D+k, in the same cycle that element k is read.
- R7: Operation 1 sums all unshifted products in 64 bits and rounds and shifts that sum once. It makes a single write to D (not advanced), in the cycle of the last element.
- R8: Operation 2 multiplies A by the signed low 16 bits of `scale_data` (register 1) instead of B. It then adds the full 32-bit B register to the shifted product.
- R9: A write addressed to register 0 is suppressed: `wr_en` stays low for that element.
- R10: A legal instruction accepted at a clock edge holds `busy` high for exactly count+1 cycles, starting with the next cycle. `done` is high for one cycle, in the cycle after the last element.
- R11: Modes 3, 7 and 8 to 15, and operation 3, are illegal. An illegal instruction makes no write, never raises `busy`, and pulses `done` in the cycle after it is accepted.
- R12: `start` is ignored while `busy` is high. The running instruction continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept `instr` at this edge when idle |
| instr | input | 32 | Multiply-group instruction word |
| busy | output | 1 | An instruction is stepping through its elements |
| done | output | 1 | One-cycle completion pulse |
| rd_a_idx | output | 7 | Source A register index for this element |
| rd_a_data | input | 32 | Register file contents at `rd_a_idx` |
| rd_b_idx | output | 7 | Source B register index for this element |
| rd_b_data | input | 32 | Register file contents at `rd_b_idx` |
| scale_data | input | 32 | Contents of register 1, the scale register |
| wr_en | output | 1 | Write strobe to the register file |
| wr_idx | output | 7 | Destination register index |
| wr_data | output | 32 | Result written to `wr_idx` |

## Verification
Suppose an instruction is accepted at edge N. Element k is then presented during the cycle after edge N+k, and its write, when it has one, appears in that same cycle. The write commits at edge N+k+1. `done` appears in the cycle after edge N+count+1. For an illegal word, `done` appears in the cycle after edge N. The bench keeps a behavioural model of the register file. When an instruction is issued, the model plays the whole instruction out against a copy of the file and stores the expected `busy`, `done` and write values, each keyed by the absolute cycle number. Every falling edge then compares the outputs against the entry for that cycle.

// File: rtl/vms_pkg.sv
// Shared types and decode for the vector multiply unit.
// Assumes the fixed 32-bit multiply-group instruction layout.
package vms_pkg;
    localparam int INSTR_W = 32;
    localparam int IDX_W   = 7;
    localparam int CNT_W   = 4;
    localparam int MODE_W  = 4;

    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_DOT  = 2'd1,
        OP_SAXP = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    typedef struct packed {
        logic             wide;
        logic [1:0]       shsel;
        logic             rnd;
        op_e              op;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] a;
        logic [IDX_W-1:0] d;
        logic [IDX_W-1:0] b;
    } cmd_t;

    // Split an instruction word into its fields.
    function automatic cmd_t decode(input logic [INSTR_W-1:0] w);
        cmd_t c;
        c.wide  = w[30];
        c.shsel = w[29:28];
        c.rnd   = w[23];
        c.op    = op_e'(w[22:21]);
        c.cnt   = w[27:24];
        c.a     = w[20:14];
        c.d     = w[13:7];
        c.b     = w[6:0];
        return c;
    endfunction

    // True when mode and operation are both supported.
    function automatic logic legal(input logic [INSTR_W-1:0] w);
        return (w[31] == 1'b0) && (w[29:28] != 2'b11) && (w[22:21] != 2'b11);
    endfunction
endpackage

// File: rtl/vms_seq.sv
// Element sequencer: accepts an instruction when idle, then steps one
// element per clock and produces the register indices for each element.
// Assumes the register file answers reads combinationally.
module vms_seq
    import vms_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    output logic               busy,
    output logic               done,
    output logic               accept,
    output logic               last,
    output cmd_t               cmd,
    output logic [IDX_W-1:0]   a_idx,
    output logic [IDX_W-1:0]   b_idx,
    output logic [IDX_W-1:0]   d_idx
);
    logic [CNT_W-1:0] k;

    assign accept = start && !busy;
    assign last   = busy && (k == cmd.cnt);

    // Latch the command, count elements and raise the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            k    <= '0;
            cmd  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                cmd <= decode(instr);
                k   <= '0;
                if (legal(instr)) busy <= 1'b1;
                else              done <= 1'b1;
            end else if (busy) begin
                if (k == cmd.cnt) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    k <= k + 1'b1;
                end
            end
        end
    end

    // Element indices: sources always advance; the dot destination stays put.
    always_comb begin
        a_idx = cmd.a + IDX_W'(k);
        b_idx = cmd.b + IDX_W'(k);
        d_idx = (cmd.op == OP_DOT) ? cmd.d : cmd.d + IDX_W'(k);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R10
    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> a_idx == $past(a_idx) + 1'b1); // R2
endmodule

// File: rtl/vms_arith.sv
// Multiply, optional accumulate, round and shift for one element.
// Assumes shsel is 0..2; purely combinational.
module vms_arith
    import vms_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16,
    parameter int ACC_W  = 64
) (
    input  logic                    wide,
    input  logic [1:0]              shsel,
    input  logic                    rnd,
    input  op_e                     op,
    input  logic [DATA_W-1:0]       a,
    input  logic [DATA_W-1:0]       b,
    input  logic [DATA_W-1:0]       s,
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [ACC_W-1:0] prod,
    output logic [DATA_W-1:0]       result
);
    localparam int NSH = 3;
    localparam int SH_STEP = 8;

    logic signed [ACC_W-1:0] opa, opb, base, sel;
    logic signed [ACC_W-1:0] scaled [NSH];
    logic [HALF_W-1:0] mul_b;

    // Sign-extend operands and form the product.
    always_comb begin
        mul_b = (op == OP_SAXP) ? s[HALF_W-1:0] : b[HALF_W-1:0];
        opa   = wide ? {{(ACC_W-DATA_W){a[DATA_W-1]}}, a}
                     : {{(ACC_W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
        opb   = {{(ACC_W-HALF_W){mul_b[HALF_W-1]}}, mul_b};
        prod  = opa * opb;
        base  = (op == OP_DOT) ? acc + prod : prod;
    end

    // One rounding/shift path per shift amount.
    for (genvar g = 0; g < NSH; g++) begin : g_shift
        localparam int SH = g * SH_STEP;
        if (SH == 0) begin : g_none
            assign scaled[g] = base;
        end else begin : g_some
            localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (SH - 1);
            assign scaled[g] = (base + (rnd ? HALF : '0)) >>> SH;
        end
    end

    // Pick the shift variant and apply the scaled-add term.
    always_comb begin
        sel    = (shsel < 2'(NSH)) ? scaled[shsel] : '0;
        result = (op == OP_SAXP) ? sel[DATA_W-1:0] + b : sel[DATA_W-1:0];
    end
endmodule

// File: rtl/vms_unit.sv
// Top of the vector multiply / dot / scaled-add unit. Drives register file
// read indices, writes one result per element (or one per dot product).
// Assumes the register file read data is valid in the cycle of the index.
module vms_unit
    import vms_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16,
    parameter int ACC_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    output logic               busy,
    output logic               done,
    output logic [IDX_W-1:0]   rd_a_idx,
    input  logic [DATA_W-1:0]  rd_a_data,
    output logic [IDX_W-1:0]   rd_b_idx,
    input  logic [DATA_W-1:0]  rd_b_data,
    input  logic [DATA_W-1:0]  scale_data,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [DATA_W-1:0]  wr_data
);
    cmd_t cmd;
    logic accept, last;
    logic [IDX_W-1:0] d_idx;
    logic signed [ACC_W-1:0] acc, prod;

    vms_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .busy(busy), .done(done), .accept(accept), .last(last), .cmd(cmd),
        .a_idx(rd_a_idx), .b_idx(rd_b_idx), .d_idx(d_idx)
    );

    vms_arith #(.DATA_W(DATA_W), .HALF_W(HALF_W), .ACC_W(ACC_W)) u_arith (
        .wide(cmd.wide), .shsel(cmd.shsel), .rnd(cmd.rnd), .op(cmd.op),
        .a(rd_a_data), .b(rd_b_data), .s(scale_data), .acc(acc),
        .prod(prod), .result(wr_data)
    );

    // Running dot-product sum, cleared when an instruction is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (accept) acc <= '0;
        else if (busy)   acc <= acc + prod;
    end

    // Write strobe: skip register 0, and for dot only on the last element.
    always_comb begin
        wr_idx = d_idx;
        wr_en  = busy && (d_idx != '0) && ((cmd.op != OP_DOT) || last);
    end

    AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx != '0); // R9
    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy); // R11
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !last |=> busy); // R12
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> !busy && !done); // R1
endmodule

// File: tb/vms_unit_test.sv
module vms_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] instr = '0;
    logic busy, done, wr_en;
    logic [6:0] rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] wr_data;
    logic [31:0] rf [128];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    string tag = "R1";

    bit      exp_busy [int];
    bit      exp_done [int];
    int      exp_widx [int];
    int      exp_wdat [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    vms_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .busy(busy), .done(done),
        .rd_a_idx(rd_a_idx), .rd_a_data(rf[rd_a_idx]),
        .rd_b_idx(rd_b_idx), .rd_b_data(rf[rd_b_idx]),
        .scale_data(rf[1]),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Register file behaviour and cycle counter.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 128; i++)
                rf[i] <= (i * 32'h0123_4567) ^ ((i % 3 == 0) ? 32'hFFF0_8000 : 32'h0000_7F00);
        end else if (wr_en) begin
            rf[wr_idx] <= wr_data;
        end
        if (cyc > LIMIT) begin
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Per-cycle comparison against the stored expectations.
    always @(negedge clk) begin
        if (rst_n) begin
            bit eb, ed, ew;
            eb = exp_busy.exists(cyc);
            ed = exp_done.exists(cyc);
            ew = exp_widx.exists(cyc);
            checks++;
            if (busy !== eb || done !== ed) begin
                fails++;
                $display("FAIL R10 %s cyc %0d: busy/done actual %b/%b expected %b/%b",
                         tag, cyc, busy, done, eb, ed);
            end
            checks++;
            if (wr_en !== ew) begin
                fails++;
                $display("FAIL %s cyc %0d: wr_en actual %b expected %b", tag, cyc, wr_en, ew);
            end else if (ew && (wr_idx !== 7'(exp_widx[cyc]) || wr_data !== 32'(exp_wdat[cyc]))) begin
                fails++;
                $display("FAIL %s cyc %0d: write actual r%0d=%h expected r%0d=%h",
                         tag, cyc, wr_idx, wr_data, exp_widx[cyc], 32'(exp_wdat[cyc]));
            end
        end
    end

    function automatic logic [31:0] mk(int mode, int rnd, int op, int cnt, int a, int d, int b);
        return {4'(mode), 4'(cnt), 1'(rnd), 2'(op), 7'(a), 7'(d), 7'(b)};
    endfunction

    // Play the instruction against a copy of the register file; N is the accept edge count.
    task automatic model(logic [31:0] w, int n);
        int m [128];
        int mode, op, cnt, sh;
        bit ok, rnd, wide;
        longint acc, r, x, y, p;
        for (int i = 0; i < 128; i++) m[i] = int'(rf[i]);
        mode = int'(w[31:28]); op = int'(w[22:21]); cnt = int'(w[27:24]);
        rnd = w[23]; wide = (mode >= 4);
        ok = (mode inside {0, 1, 2, 4, 5, 6}) && op != 3;
        if (!ok) begin
            exp_done[n + 1] = 1'b1;
            return;
        end
        sh = (mode % 4) * 8;
        r = (rnd && sh > 0) ? (longint'(1) <<< (sh - 1)) : 0;
        acc = 0;
        for (int k = 0; k <= cnt; k++) begin
            int ai, bi, di, av, bv, sv, res;
            bit wr;
            ai = (int'(w[20:14]) + k) % 128;
            bi = (int'(w[6:0]) + k) % 128;
            di = (op == 1) ? int'(w[13:7]) : (int'(w[13:7]) + k) % 128;
            av = m[ai]; bv = m[bi]; sv = m[1];
            x = wide ? longint'(av) : longint'($signed(av[15:0]));
            y = (op == 2) ? longint'($signed(sv[15:0])) : longint'($signed(bv[15:0]));
            p = x * y;
            wr = 1'b1;
            if (op == 0) res = int'((p + r) >>> sh);
            else if (op == 2) res = int'((p + r) >>> sh) + bv;
            else begin
                acc += p;
                res = int'((acc + r) >>> sh);
                wr = (k == cnt);
            end
            exp_busy[n + 1 + k] = 1'b1;
            if (wr && di != 0) begin
                exp_widx[n + 1 + k] = di;
                exp_wdat[n + 1 + k] = res;
                m[di] = res;
            end
        end
        exp_done[n + cnt + 2] = 1'b1;
    endtask

    // Issue one instruction; optionally poke a second start while busy.
    task automatic issue(string t, logic [31:0] w, bit poke);
        @(negedge clk);
        tag = t;
        model(w, cyc);
        start = 1'b1; instr = w;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < int'(w[27:24]) + 3; i++) begin
            @(negedge clk);
            if (poke && i == 0) begin
                start = 1'b1; instr = mk(0, 0, 0, 0, 5, 90, 6);
            end else begin
                start = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || wr_en !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: busy/done/wr_en actual %b%b%b expected 000", busy, done, wr_en);
        end
        rst_n = 1'b1;
        issue("R3 16x16 shift0", mk(0, 0, 0, 3, 10, 40, 20), 0);
        issue("R3 16x16 shift8", mk(1, 0, 0, 3, 11, 44, 23), 0);
        issue("R3 16x16 shift16", mk(2, 0, 0, 2, 12, 48, 27), 0);
        issue("R4 32x16 shift0", mk(4, 0, 0, 3, 30, 60, 33), 0);
        issue("R4 32x16 shift8", mk(5, 0, 0, 3, 31, 64, 36), 0);
        issue("R4 32x16 shift16", mk(6, 0, 0, 3, 32, 68, 39), 0);
        issue("R5 round shift8", mk(1, 1, 0, 3, 13, 72, 21), 0);
        issue("R5 round shift16", mk(6, 1, 0, 3, 14, 76, 22), 0);
        issue("R5 round shift0", mk(0, 1, 0, 1, 15, 80, 24), 0);
        issue("R6 sixteen elements", mk(4, 0, 0, 15, 90, 100, 50), 0);
        issue("R7 dot shift0", mk(0, 0, 1, 7, 16, 82, 25), 0);
        issue("R7 dot wide round", mk(5, 1, 1, 15, 40, 83, 60), 0);
        issue("R8 scaled add", mk(0, 0, 2, 3, 17, 84, 26), 0);
        issue("R8 scaled add round", mk(5, 1, 2, 3, 18, 88, 28), 0);
        issue("R9 dest zero", mk(0, 0, 0, 2, 20, 0, 30), 0);
        issue("R9 dot to zero", mk(0, 0, 1, 2, 20, 0, 30), 0);
        issue("R2 index wrap", mk(1, 0, 0, 4, 126, 125, 124), 0);
        issue("R11 mode 3", mk(3, 0, 0, 2, 10, 50, 20), 0);
        issue("R11 mode 9", mk(9, 0, 0, 2, 10, 50, 20), 0);
        issue("R11 op 3", mk(0, 0, 3, 2, 10, 50, 20), 0);
        issue("R12 start while busy", mk(0, 0, 0, 5, 60, 110, 70), 1);
        issue("R3 after poke", mk(2, 1, 0, 1, 3, 95, 4), 0);
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule